// File: doc/BRIEF.md
# Program Counter Update Control

This block owns the program counter of a multicycle 32-bit processor. In each cycle the sequencer supplies a 2-bit write-condition field and a 2-bit source-select field. From these the block decides whether the program counter is loaded at the next clock edge and which value it takes. The candidates are the ALU result of the current cycle, the ALU output captured in an earlier cycle, an absolute jump target built from the instruction, or register operand A. A trap request takes precedence over both fields. It forces a load of a fixed trap vector.

In the fetch cycle the ALU forms PC+4 and the block loads it through source 0. In decode the ALU adds the incremented PC and the word-scaled branch offset, and that sum is captured in the ALU output register. A later branch cycle passes register A through the ALU to set the zero flag. The write condition then picks whether the captured target (source 1) is loaded. The incremented PC output feeds the register file for link writes.

Top module: `pc_update_ctrl`

## Requirements
- R1: A low `rst_n` at a rising clock edge loads the program counter with 0x0000_0000.
- R2: Write condition 0 (never) leaves the program counter unchanged and holds `pc_we` low, whatever the source select and zero flag are.
- R3: Write condition 1 (always) loads the selected source at the next rising edge.
- R4: Write condition 2 (if zero) loads the selected source only when `alu_zero` is 1. Otherwise the program counter holds.
- R5: Write condition 3 (if not zero) loads the selected source only when `alu_zero` is 0. Otherwise the program counter holds.
- R6: Source select 0 loads `alu_live`, the ALU result of the same cycle.
- R7: Source select 1 loads `alu_held`, the registered ALU output.
- R8: Source select 2 loads {current PC bits 31:28, `jump_field` bits 25:0, 2'b00}.
- R9: Source select 3 loads `opa`, register operand A.
- R10: While `trap_req` is 1, `pc_we` is 1 and the program counter loads the trap vector 0x0000_0080. Both fields and the zero flag are ignored.
- R11: `pc_plus4` always equals the current program counter plus 4, modulo 2^32.
- R12: `pc_we` shows the load decision of the current cycle combinationally. When it is low, the program counter does not change at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_cond | input | 2 | Write condition: 0 never, 1 always, 2 if zero, 3 if not zero |
| src_sel | input | 2 | Source: 0 live ALU, 1 held ALU, 2 jump, 3 operand A |
| alu_live | input | 32 | ALU result of this cycle |
| alu_held | input | 32 | Registered ALU output |
| jump_field | input | 26 | Instruction bits 25:0, the absolute jump field |
| opa | input | 32 | Register operand A |
| alu_zero | input | 1 | ALU zero flag |
| trap_req | input | 1 | Load the trap vector this cycle |
| pc_we | output | 1 | Program counter loads at the next edge |
| pc_q | output | 32 | Current program counter |
| pc_plus4 | output | 32 | Current program counter plus 4 |

## Verification
A wrong write decision appears on `pc_we` in the same cycle and on `pc_q` one edge later. A missed or spurious branch therefore shows up within a single cycle as a stuck or jumping counter. A wrong source or a badly joined jump target shows up as the wrong `pc_q` value right after the load edge. The jump upper bits only become visible once the counter holds a nonzero top nibble, so the bench first steers the counter to such a value. The incremented output is compared after every vector, including the wrap at 0xFFFF_FFFC.

// File: rtl/pcu_pkg.sv
// Package: shared encodings for the program counter update control.
// Assumes the sequencer drives the 2-bit fields with these exact codes.
package pcu_pkg;

    typedef enum logic [1:0] {
        WR_NEVER      = 2'd0,
        WR_ALWAYS     = 2'd1,
        WR_IF_ZERO    = 2'd2,
        WR_IF_NONZERO = 2'd3
    } wr_mode_e;

    typedef enum logic [1:0] {
        SRC_ALU_LIVE = 2'd0,
        SRC_ALU_HELD = 2'd1,
        SRC_JUMP     = 2'd2,
        SRC_OPA      = 2'd3
    } src_sel_e;

endpackage

// File: rtl/pcu_write_gate.sv
// Module: pcu_write_gate
// Turns the write-condition field, the ALU zero flag and a trap request
// into the program counter load enable. Purely combinational.
// Assumes the trap request has priority over every write condition.
module pcu_write_gate
    import pcu_pkg::*;
(
    input  wr_mode_e mode,
    input  logic     zero_flag,
    input  logic     trap,
    output logic     load_en
);

    // Decide the load enable for the current cycle.
    always_comb begin
        unique case (mode)
            WR_NEVER:      load_en = 1'b0;
            WR_ALWAYS:     load_en = 1'b1;
            WR_IF_ZERO:    load_en = zero_flag;
            WR_IF_NONZERO: load_en = ~zero_flag;
            default:       load_en = 1'b0;
        endcase
        if (trap) begin
            load_en = 1'b1;
        end
    end

endmodule

// File: rtl/pcu_target_mux.sv
// Module: pcu_target_mux
// Picks the next program counter value from the four sources, or the
// trap vector when a trap is requested. It also builds the absolute jump
// target from the upper PC bits and the word-aligned jump field.
// Assumes XLEN > JFIELD_W + 2, so at least one upper PC bit remains.
module pcu_target_mux
    import pcu_pkg::*;
#(
    parameter int          XLEN     = 32,
    parameter int          JFIELD_W = 26,
    parameter logic [31:0] TRAP_VEC = 32'h0000_0080,
    localparam int         UPPER_W  = XLEN - JFIELD_W - 2
) (
    input  src_sel_e            sel,
    input  logic                trap,
    input  logic [XLEN-1:0]     alu_live,
    input  logic [XLEN-1:0]     alu_held,
    input  logic [JFIELD_W-1:0] jump_field,
    input  logic [XLEN-1:0]     opa,
    input  logic [UPPER_W-1:0]  pc_upper,
    output logic [XLEN-1:0]     pc_d
);

    logic [XLEN-1:0] jump_tgt;

    // Join the current region bits with the word-scaled jump field.
    always_comb begin
        jump_tgt = {pc_upper, jump_field, 2'b00};
    end

    // Select the next value; a trap overrides the source select.
    always_comb begin
        unique case (sel)
            SRC_ALU_LIVE: pc_d = alu_live;
            SRC_ALU_HELD: pc_d = alu_held;
            SRC_JUMP:     pc_d = jump_tgt;
            SRC_OPA:      pc_d = opa;
            default:      pc_d = alu_live;
        endcase
        if (trap) begin
            pc_d = TRAP_VEC[XLEN-1:0];
        end
    end

endmodule

// File: rtl/pcu_pc_reg.sv
// Module: pcu_pc_reg
// Holds the program counter and forms its incremented copy for link writes.
// Assumes a synchronous, active-low reset.
module pcu_pc_reg #(
    parameter int          XLEN     = 32,
    parameter logic [31:0] RESET_PC = 32'h0000_0000,
    parameter int          STEP     = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_en,
    input  logic [XLEN-1:0] pc_d,
    output logic [XLEN-1:0] pc_q,
    output logic [XLEN-1:0] pc_inc
);

    localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);

    // Register the program counter, loading only when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= RESET_PC[XLEN-1:0];
        end else if (load_en) begin
            pc_q <= pc_d;
        end
    end

    // Incremented counter for link writes; wraps at the top of the space.
    always_comb begin
        pc_inc = pc_q + STEP_V;
    end

endmodule

// File: rtl/pc_update_ctrl.sv
// Module: pc_update_ctrl
// Program counter update control for a multicycle processor. It decodes the
// write condition, selects the next value and keeps the counter register.
// Assumes the sequencer precomputes branch targets into alu_held during
// decode and resolves branches through alu_zero in a later cycle.
module pc_update_ctrl
    import pcu_pkg::*;
#(
    parameter int          XLEN     = 32,
    parameter int          JFIELD_W = 26,
    parameter logic [31:0] TRAP_VEC = 32'h0000_0080,
    parameter logic [31:0] RESET_PC = 32'h0000_0000,
    parameter int          STEP     = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          wr_cond,
    input  logic [1:0]          src_sel,
    input  logic [XLEN-1:0]     alu_live,
    input  logic [XLEN-1:0]     alu_held,
    input  logic [JFIELD_W-1:0] jump_field,
    input  logic [XLEN-1:0]     opa,
    input  logic                alu_zero,
    input  logic                trap_req,
    output logic                pc_we,
    output logic [XLEN-1:0]     pc_q,
    output logic [XLEN-1:0]     pc_plus4
);

    localparam int UPPER_W = XLEN - JFIELD_W - 2;

    wr_mode_e        mode;
    src_sel_e        sel;
    logic [XLEN-1:0] pc_d;

    // Give the raw control fields their enumerated meaning.
    always_comb begin
        mode = wr_mode_e'(wr_cond);
        sel  = src_sel_e'(src_sel);
    end

    pcu_write_gate u_gate (
        .mode      (mode),
        .zero_flag (alu_zero),
        .trap      (trap_req),
        .load_en   (pc_we)
    );

    pcu_target_mux #(
        .XLEN     (XLEN),
        .JFIELD_W (JFIELD_W),
        .TRAP_VEC (TRAP_VEC)
    ) u_mux (
        .sel        (sel),
        .trap       (trap_req),
        .alu_live   (alu_live),
        .alu_held   (alu_held),
        .jump_field (jump_field),
        .opa        (opa),
        .pc_upper   (pc_q[XLEN-1 -: UPPER_W]),
        .pc_d       (pc_d)
    );

    pcu_pc_reg #(
        .XLEN     (XLEN),
        .RESET_PC (RESET_PC),
        .STEP     (STEP)
    ) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (pc_we),
        .pc_d    (pc_d),
        .pc_q    (pc_q),
        .pc_inc  (pc_plus4)
    );

endmodule

// File: rtl/pcu_checker.sv
// Module: pcu_checker
// Temporal checks on the ports of pc_update_ctrl, attached with bind.
module pcu_checker #(
    parameter int          XLEN     = 32,
    parameter int          JFIELD_W = 26,
    parameter logic [31:0] TRAP_VEC = 32'h0000_0080,
    parameter logic [31:0] RESET_PC = 32'h0000_0000,
    parameter int          STEP     = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          wr_cond,
    input logic [1:0]          src_sel,
    input logic [XLEN-1:0]     alu_live,
    input logic [XLEN-1:0]     alu_held,
    input logic [JFIELD_W-1:0] jump_field,
    input logic [XLEN-1:0]     opa,
    input logic                alu_zero,
    input logic                trap_req,
    input logic                pc_we,
    input logic [XLEN-1:0]     pc_q,
    input logic [XLEN-1:0]     pc_plus4
);

    localparam int UPPER_W = XLEN - JFIELD_W - 2;

    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |=> pc_q == RESET_PC[XLEN-1:0]);

    a_r2_never_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cond == 2'd0 && !trap_req) |=> $stable(pc_q));

    a_r6_live_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cond == 2'd1 && src_sel == 2'd0 && !trap_req) |=> pc_q == $past(alu_live));

    a_r4_zero_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cond == 2'd2 && alu_zero && src_sel == 2'd1 && !trap_req)
        |=> pc_q == $past(alu_held));

    a_r5_nonzero_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cond == 2'd3 && alu_zero && !trap_req) |=> $stable(pc_q));

    a_r8_jump_join: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cond == 2'd1 && src_sel == 2'd2 && !trap_req)
        |=> pc_q == {$past(pc_q[XLEN-1 -: UPPER_W]), $past(jump_field), 2'b00});

    a_r9_opa_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cond == 2'd1 && src_sel == 2'd3 && !trap_req) |=> pc_q == $past(opa));

    a_r10_trap_vec: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> pc_we);

    a_r10_trap_load: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> pc_q == TRAP_VEC[XLEN-1:0]);

    a_r11_increment: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_plus4 - pc_q) == XLEN'(STEP));

    a_r12_no_we_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_we |=> $stable(pc_q));

endmodule

bind pc_update_ctrl pcu_checker #(
    .XLEN     (XLEN),
    .JFIELD_W (JFIELD_W),
    .TRAP_VEC (TRAP_VEC),
    .RESET_PC (RESET_PC),
    .STEP     (STEP)
) u_pcu_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_cond    (wr_cond),
    .src_sel    (src_sel),
    .alu_live   (alu_live),
    .alu_held   (alu_held),
    .jump_field (jump_field),
    .opa        (opa),
    .alu_zero   (alu_zero),
    .trap_req   (trap_req),
    .pc_we      (pc_we),
    .pc_q       (pc_q),
    .pc_plus4   (pc_plus4)
);

// File: tb/tb_pc_update_ctrl.sv
// Bench for pc_update_ctrl: a table of vectors walked in order, then
// directed checks of reset and holding behaviour.
module tb_pc_update_ctrl;

    typedef struct packed {
        logic [1:0]  wc;
        logic [1:0]  src;
        logic [31:0] live;
        logic [31:0] held;
        logic [25:0] jf;
        logic [31:0] a;
        logic        z;
        logic        trap;
        logic        we;
        logic [31:0] pc;
    } vec_t;

    localparam int NV = 13;
    // Vectors run in sequence; each expected pc follows from the one before.
    localparam vec_t VEC [NV] = '{
        '{2'd1, 2'd0, 32'h4,   32'h0,   26'h0, 32'h0,          1'b0, 1'b0, 1'b1, 32'h4},          // R3 R6 fetch
        '{2'd0, 2'd0, 32'h999, 32'h0,   26'h0, 32'h0,          1'b1, 1'b0, 1'b0, 32'h4},          // R2 never
        '{2'd1, 2'd1, 32'h0,   32'h28,  26'h0, 32'h0,          1'b0, 1'b0, 1'b1, 32'h28},         // R7 held
        '{2'd2, 2'd1, 32'h0,   32'h100, 26'h0, 32'h0,          1'b0, 1'b0, 1'b0, 32'h28},         // R4 not taken
        '{2'd2, 2'd1, 32'h0,   32'h100, 26'h0, 32'h0,          1'b1, 1'b0, 1'b1, 32'h100},        // R4 taken
        '{2'd3, 2'd1, 32'h0,   32'h200, 26'h0, 32'h0,          1'b1, 1'b0, 1'b0, 32'h100},        // R5 not taken
        '{2'd3, 2'd1, 32'h0,   32'h200, 26'h0, 32'h0,          1'b0, 1'b0, 1'b1, 32'h200},        // R5 taken
        '{2'd1, 2'd3, 32'h0,   32'h0,   26'h0, 32'hF000_0010,  1'b0, 1'b0, 1'b1, 32'hF000_0010},  // R9 operand A
        '{2'd1, 2'd2, 32'h0,   32'h0,   26'h40, 32'h0,         1'b0, 1'b0, 1'b1, 32'hF000_0100},  // R8 jump keeps region
        '{2'd1, 2'd2, 32'h0,   32'h0,   26'h3FF_FFFF, 32'h0,   1'b0, 1'b0, 1'b1, 32'hFFFF_FFFC},  // R8 max field, R11 wrap next
        '{2'd0, 2'd0, 32'h0,   32'h0,   26'h0, 32'h0,          1'b0, 1'b1, 1'b1, 32'h80},         // R10 trap over never
        '{2'd3, 2'd3, 32'h0,   32'h0,   26'h0, 32'h1234,       1'b1, 1'b1, 1'b1, 32'h80},         // R10 trap over source
        '{2'd1, 2'd3, 32'h0,   32'h0,   26'h0, 32'h1234,       1'b0, 1'b0, 1'b1, 32'h1234}        // R9 operand A
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  wr_cond = '0;
    logic [1:0]  src_sel = '0;
    logic [31:0] alu_live = '0;
    logic [31:0] alu_held = '0;
    logic [25:0] jump_field = '0;
    logic [31:0] opa = '0;
    logic        alu_zero = 1'b0;
    logic        trap_req = 1'b0;
    logic        pc_we;
    logic [31:0] pc_q;
    logic [31:0] pc_plus4;

    int n_checks = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    pc_update_ctrl dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_cond    (wr_cond),
        .src_sel    (src_sel),
        .alu_live   (alu_live),
        .alu_held   (alu_held),
        .jump_field (jump_field),
        .opa        (opa),
        .alu_zero   (alu_zero),
        .trap_req   (trap_req),
        .pc_we      (pc_we),
        .pc_q       (pc_q),
        .pc_plus4   (pc_plus4)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset pc", pc_q, 32'h0);
        check("R11 reset plus4", pc_plus4, 32'h4);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            wr_cond    = VEC[i].wc;
            src_sel    = VEC[i].src;
            alu_live   = VEC[i].live;
            alu_held   = VEC[i].held;
            jump_field = VEC[i].jf;
            opa        = VEC[i].a;
            alu_zero   = VEC[i].z;
            trap_req   = VEC[i].trap;
            #1;
            check($sformatf("R12 we vec %0d", i), {31'b0, pc_we}, {31'b0, VEC[i].we});
            @(posedge clk);
            #1;
            check($sformatf("R3-series pc vec %0d", i), pc_q, VEC[i].pc);
            check($sformatf("R11 plus4 vec %0d", i), pc_plus4, VEC[i].pc + 32'd4);
            @(negedge clk);
        end

        // R2: several never cycles with mixed inputs leave pc at 0x1234.
        wr_cond = 2'd0; src_sel = 2'd2; alu_zero = 1'b1; jump_field = 26'h155;
        repeat (3) @(posedge clk);
        #1;
        check("R2 hold over cycles", pc_q, 32'h1234);
        check("R2 we low", {31'b0, pc_we}, 32'h0);

        // R1: reset mid-run wins over an always-load.
        @(negedge clk);
        rst_n = 1'b0; wr_cond = 2'd1; src_sel = 2'd3; opa = 32'h5555;
        @(posedge clk);
        #1;
        check("R1 reset mid-run", pc_q, 32'h0);
        @(negedge clk);
        rst_n = 1'b1; wr_cond = 2'd0; trap_req = 1'b0;
        @(posedge clk);
        #1;
        check("R1 after release", pc_q, 32'h0);
        finish_run();
    end

endmodule